// File: doc/BRIEF.md
# Memory Bitfield Read-Modify-Write Sequencer

This block carries out bit-field operations on memory that is addressed by the byte. A field is between 1 and 32 bits wide. It starts at any signed bit offset from a base byte address, so it can straddle up to five bytes. The block handles three operations:

- **Fill:** set every bit of the field to one.
- **Insert:** replace the field with the low bits of a source value.
- **Find-first-one:** report where the first set bit of the field lies, without writing anything.

Bit numbering runs from the most significant bit of the byte at the base address. Offset 0 is bit 7 of that byte, offset 8 is bit 7 of the next byte, and a negative offset reaches lower addresses.

For each operation the sequencer reads a five-byte window: a 32-bit word and then one trailing byte. It registers the condition flags of the field as it stood before any change. For fill and insert it then builds the new contents and writes back the word. It also writes the trailing byte, but only when the field reaches into it. A one-cycle `done` pulse ends every operation.

The memory port uses a request/acknowledge handshake, which acts as valid/ready. The sequencer raises `mem_req` and holds `mem_addr`, `mem_we`, `mem_size` and `mem_wdata` unchanged until it samples `mem_ack` high on a clock edge. That edge completes the transfer. Memory may stall for any number of cycles by keeping `mem_ack` low, and it must only assert `mem_ack` while `mem_req` is high. Words are big-endian: the byte at the word address occupies bits 31:24. Byte transfers use data bits 7:0.

Top module: `bitfield_rmw_seq`

## Requirements
- R1: The word address is `base_addr` plus the bit offset arithmetically shifted right by 3, wrapped modulo 2^24. The sequencer reads a word (`mem_size`=1) at that address and then a byte (`mem_size`=0) at the word address + 4, also wrapped, before any write.
- R2: A `width_code` of 0 selects a 32-bit field. Any other value selects a field of that many bits.
- R3: At `done`, `flag_n` is the first (most significant) bit of the field before modification and `flag_z` is 1 when that field was all zeros. `flag_v` and `flag_c` are 0.
- R4: Op code 2'b00 (fill) sets every field bit to one and leaves every bit outside the field in the five-byte window unchanged. It performs exactly one word write.
- R5: Op code 2'b01 (insert) writes bits `width`-1..0 of `ins_val` into the field, in order from the field's first bit. Bits outside the field are unchanged.
- R6: The trailing byte is written only when (offset mod 8) + width > 32, and only after the word write. In that case only its top (offset mod 8 + width - 32) bits change.
- R7: Op code 2'b10 (find-first-one; 2'b11 behaves the same) issues no write. `ffo_result` is the offset plus the number of zero bits before the first one in the field, or offset + width when the field is zero.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we`, `mem_size` and `mem_wdata` stay unchanged in the next cycle.
- R9: `done` is high for exactly one cycle per operation and `busy` is low in the cycle after it. A `start` seen while `busy` is high is ignored.
- R10: After reset `busy`, `done` and `mem_req` are low, and `mem_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 00 fill, 01 insert, 10/11 find-first-one |
| base_addr | input | 24 | Base byte address |
| bit_off | input | 32 | Signed bit offset |
| width_code | input | 5 | Field width, 0 meaning 32 |
| ins_val | input | 32 | Insert source, low bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_n | output | 1 | Field MSB before modification |
| flag_z | output | 1 | Field was zero |
| flag_v | output | 1 | Always 0 |
| flag_c | output | 1 | Always 0 |
| ffo_result | output | 32 | Find-first-one result offset |
| mem_req | output | 1 | Memory request (valid) |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 1 | 1 word, 0 byte |
| mem_addr | output | 24 | Byte address of the access |
| mem_wdata | output | 32 | Write data (byte in bits 7:0) |
| mem_ack | input | 1 | Memory acknowledge (ready) |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on reads |

## Verification
The sweep visits every width, including the encoded 32, at offsets that cover all eight sub-byte positions, both negative and positive. A wrong shift or mask therefore shows up as a corrupted neighbour bit anywhere in the five-byte window. Fields that end exactly at bit 32, or one bit past it, separate a design that writes the trailing byte needlessly (an extra byte write) from one that skips it (lost field bits). Bases near the top of the 24-bit space catch address carries that are not wrapped. A second `start` pulsed mid-operation and random acknowledge latency catch a sequencer that restarts or lets its request drift before the acknowledge.

// File: rtl/bfrmw_pkg.sv
package bfrmw_pkg;

  typedef enum logic [1:0] {
    OP_FILL = 2'b00,
    OP_INS  = 2'b01,
    OP_FFO  = 2'b10,
    OP_FFO2 = 2'b11
  } bf_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WORD,
    ST_RD_BYTE,
    ST_MODIFY,
    ST_WR_WORD,
    ST_WR_BYTE,
    ST_DONE
  } bf_state_e;

endpackage

// File: rtl/bf_addr_calc.sv
// Computes the word address of the five-byte window and its trailing byte.
module bf_addr_calc #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] word_addr,
  output logic [ADDR_W-1:0] byte_addr
);
  localparam int TAIL_OFS = 4;

  // Signed byte displacement, sign-extended or truncated to the address width.
  assign word_addr = base + ADDR_W'($signed(off) >>> 3);
  assign byte_addr = word_addr + ADDR_W'(TAIL_OFS);
endmodule

// File: rtl/bf_field_extract.sv
// Aligns the field to the top of a word, derives flags and leading-zero count.
module bf_field_extract #(
  parameter int DATA_W = 32,
  parameter int WID_W  = 6
) (
  input  logic [DATA_W-1:0] win_word,
  input  logic [7:0]        win_byte,
  input  logic [2:0]        sh,
  input  logic [WID_W-1:0]  width,
  output logic [DATA_W-1:0] fmask,
  output logic              flag_n,
  output logic              flag_z,
  output logic [WID_W-1:0]  lead
);
  localparam int WIN_W = DATA_W + 8;

  logic [WIN_W-1:0]  win_sh;
  logic [DATA_W-1:0] field_left;

  assign win_sh     = {win_word, win_byte} << sh;
  assign fmask      = {DATA_W{1'b1}} << (WID_W'(DATA_W) - width);
  assign field_left = win_sh[WIN_W-1:8] & fmask;
  assign flag_n     = win_sh[WIN_W-1];
  assign flag_z     = ~|field_left;

  // Scanning upward, the last hit is the highest set bit.
  always_comb begin
    lead = width;
    for (int i = 0; i < DATA_W; i++) begin
      if (field_left[i]) lead = WID_W'(DATA_W - 1 - i);
    end
  end
endmodule

// File: rtl/bf_field_merge.sv
// Places the fill value into the window and decides on the trailing byte write.
module bf_field_merge #(
  parameter int DATA_W = 32,
  parameter int WID_W  = 6
) (
  input  logic [DATA_W-1:0] win_word,
  input  logic [7:0]        win_byte,
  input  logic [2:0]        sh,
  input  logic [WID_W-1:0]  width,
  input  logic [DATA_W-1:0] fmask,
  input  logic [DATA_W-1:0] fill_val,
  output logic [DATA_W-1:0] new_word,
  output logic [7:0]        new_byte,
  output logic              need_byte
);
  localparam int WIN_W = DATA_W + 8;

  logic [DATA_W-1:0] src_left;
  logic [WIN_W-1:0]  mask_w;
  logic [WIN_W-1:0]  pos_w;
  logic [WIN_W-1:0]  merged;
  logic [WID_W:0]    span;

  assign src_left = fill_val << (WID_W'(DATA_W) - width);
  assign mask_w   = {fmask, 8'h00} >> sh;
  assign pos_w    = {src_left, 8'h00} >> sh;
  assign merged   = ({win_word, win_byte} & ~mask_w) | (pos_w & mask_w);
  assign new_word = merged[WIN_W-1:8];
  assign new_byte = merged[7:0];

  assign span      = (WID_W+1)'(sh) + (WID_W+1)'(width);
  assign need_byte = span > (WID_W+1)'(DATA_W);
endmodule

// File: rtl/bitfield_rmw_seq.sv
module bitfield_rmw_seq
  import bfrmw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [1:0]                op,
  input  logic [ADDR_W-1:0]         base_addr,
  input  logic [OFF_W-1:0]          bit_off,
  input  logic [$clog2(DATA_W)-1:0] width_code,
  input  logic [DATA_W-1:0]         ins_val,
  output logic                      busy,
  output logic                      done,
  output logic                      flag_n,
  output logic                      flag_z,
  output logic                      flag_v,
  output logic                      flag_c,
  output logic [OFF_W-1:0]          ffo_result,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic                      mem_size,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic                      mem_ack,
  input  logic [DATA_W-1:0]         mem_rdata
);
  localparam int CW    = $clog2(DATA_W);
  localparam int WID_W = CW + 1;

  bf_state_e         st;
  bf_op_e            op_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [WID_W-1:0]  wid_q;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] word_q;
  logic [7:0]        byte_q;
  logic [DATA_W-1:0] new_word_q;
  logic [7:0]        new_byte_q;
  logic              need_q;
  logic              flag_n_q;
  logic              flag_z_q;
  logic [OFF_W-1:0]  ffo_q;

  logic [ADDR_W-1:0] word_addr;
  logic [ADDR_W-1:0] byte_addr;
  logic [DATA_W-1:0] fmask;
  logic              ext_n;
  logic              ext_z;
  logic [WID_W-1:0]  lead;
  logic [DATA_W-1:0] fill_val;
  logic [DATA_W-1:0] mrg_word;
  logic [7:0]        mrg_byte;
  logic              mrg_need;
  logic [WID_W-1:0]  wid_dec;
  logic              xfer;

  assign wid_dec  = (width_code == '0) ? WID_W'(DATA_W) : {1'b0, width_code};
  assign fill_val = (op_q == OP_INS) ? src_q : '1;
  assign xfer     = mem_req && mem_ack;

  bf_addr_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base      (base_q),
    .off       (off_q),
    .word_addr (word_addr),
    .byte_addr (byte_addr)
  );

  bf_field_extract #(.DATA_W(DATA_W), .WID_W(WID_W)) u_extract (
    .win_word (word_q),
    .win_byte (byte_q),
    .sh       (off_q[2:0]),
    .width    (wid_q),
    .fmask    (fmask),
    .flag_n   (ext_n),
    .flag_z   (ext_z),
    .lead     (lead)
  );

  bf_field_merge #(.DATA_W(DATA_W), .WID_W(WID_W)) u_merge (
    .win_word  (word_q),
    .win_byte  (byte_q),
    .sh        (off_q[2:0]),
    .width     (wid_q),
    .fmask     (fmask),
    .fill_val  (fill_val),
    .new_word  (mrg_word),
    .new_byte  (mrg_byte),
    .need_byte (mrg_need)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      op_q       <= OP_FILL;
      base_q     <= '0;
      off_q      <= '0;
      wid_q      <= '0;
      src_q      <= '0;
      word_q     <= '0;
      byte_q     <= '0;
      new_word_q <= '0;
      new_byte_q <= '0;
      need_q     <= 1'b0;
      flag_n_q   <= 1'b0;
      flag_z_q   <= 1'b0;
      ffo_q      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            op_q   <= bf_op_e'(op);
            base_q <= base_addr;
            off_q  <= bit_off;
            wid_q  <= wid_dec;
            src_q  <= ins_val;
            st     <= ST_RD_WORD;
          end
        end
        ST_RD_WORD: begin
          if (xfer) begin
            word_q <= mem_rdata;
            st     <= ST_RD_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (xfer) begin
            byte_q <= mem_rdata[7:0];
            st     <= ST_MODIFY;
          end
        end
        ST_MODIFY: begin
          flag_n_q   <= ext_n;
          flag_z_q   <= ext_z;
          ffo_q      <= off_q + OFF_W'(lead);
          new_word_q <= mrg_word;
          new_byte_q <= mrg_byte;
          need_q     <= mrg_need;
          st         <= op_q[1] ? ST_DONE : ST_WR_WORD;
        end
        ST_WR_WORD: begin
          if (xfer) st <= need_q ? ST_WR_BYTE : ST_DONE;
        end
        ST_WR_BYTE: begin
          if (xfer) st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_DONE);

  assign mem_req   = (st == ST_RD_WORD) || (st == ST_RD_BYTE) ||
                     (st == ST_WR_WORD) || (st == ST_WR_BYTE);
  assign mem_we    = (st == ST_WR_WORD) || (st == ST_WR_BYTE);
  assign mem_size  = (st == ST_RD_WORD) || (st == ST_WR_WORD);
  assign mem_addr  = ((st == ST_RD_BYTE) || (st == ST_WR_BYTE)) ? byte_addr : word_addr;
  assign mem_wdata = (st == ST_WR_BYTE) ? {{(DATA_W-8){1'b0}}, new_byte_q} : new_word_q;

  assign flag_n     = flag_n_q;
  assign flag_z     = flag_z_q;
  assign flag_v     = 1'b0;
  assign flag_c     = 1'b0;
  assign ffo_result = ffo_q;
endmodule

// File: rtl/bfrmw_chk.sv
module bfrmw_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        op,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic              mem_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  logic ffo_act;
  logic word_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ffo_act   <= 1'b0;
      word_done <= 1'b0;
    end else begin
      if (start && !busy) begin
        ffo_act   <= op[1];
        word_done <= 1'b0;
      end else if (done) begin
        ffo_act <= 1'b0;
      end
      if (mem_req && mem_ack && mem_we && mem_size) word_done <= 1'b1;
    end
  end

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_size) && $stable(mem_wdata)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R7
  ffo_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ffo_act |-> !(mem_req && mem_we));

  // R6
  byte_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_size) |-> word_done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind bitfield_rmw_seq bfrmw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/bitfield_rmw_seq_tb.sv
`timescale 1ns/1ps
module bitfield_rmw_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [23:0] base_addr = '0;
  logic [31:0] bit_off = '0;
  logic [4:0]  width_code = '0;
  logic [31:0] ins_val = '0;
  logic        busy, done, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] ffo_result;
  logic        mem_req, mem_we, mem_size;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  bitfield_rmw_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
    .bit_off(bit_off), .width_code(width_code), .ins_val(ins_val),
    .busy(busy), .done(done), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .ffo_result(ffo_result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  logic [7:0] mem     [0:63];
  logic [7:0] ref_mem [0:63];
  int checks = 0;
  int fails  = 0;
  int word_wr_cnt, byte_wr_cnt;
  logic [23:0] rd_word_addr, rd_byte_addr;
  bit   hold_err;
  int   lat = 0;
  int unsigned lat_seed = 32'h1234_5678;
  int unsigned rng = 32'hC0FF_EE11;
  bit   pend = 1'b0;
  logic [23:0] pend_addr;
  logic [31:0] pend_wdata;
  logic        pend_we, pend_size;

  // Behavioural memory: big-endian words, random acknowledge latency 0..2.
  always @(negedge clk) begin
    logic [5:0] idx;
    if (pend && mem_req && !mem_ack) begin
      if (mem_addr != pend_addr || mem_we != pend_we || mem_size != pend_size ||
          mem_wdata != pend_wdata) hold_err = 1'b1;
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
      pend = 1'b0;
    end else if (mem_req) begin
      pend = 1'b1;
      pend_addr = mem_addr; pend_we = mem_we; pend_size = mem_size; pend_wdata = mem_wdata;
      if (lat != 0) begin
        lat--;
      end else begin
        idx = mem_addr[5:0];
        if (mem_we) begin
          if (mem_size) begin
            mem[idx] = mem_wdata[31:24];
            mem[6'(idx+1)] = mem_wdata[23:16];
            mem[6'(idx+2)] = mem_wdata[15:8];
            mem[6'(idx+3)] = mem_wdata[7:0];
            word_wr_cnt++;
          end else begin
            mem[idx] = mem_wdata[7:0];
            byte_wr_cnt++;
          end
        end else begin
          if (mem_size) begin
            mem_rdata = {mem[idx], mem[6'(idx+1)], mem[6'(idx+2)], mem[6'(idx+3)]};
            rd_word_addr = mem_addr;
          end else begin
            mem_rdata = {24'h0, mem[idx]};
            rd_byte_addr = mem_addr;
          end
        end
        mem_ack = 1'b1;
        lat_seed = lat_seed * 32'd1664525 + 32'd1013904223;
        lat = int'(lat_seed[17:16]) % 3;
      end
    end
  end

  function automatic logic [31:0] next_rng();
    rng = rng * 32'd1103515245 + 32'd12345;
    return {rng[23:16], rng[31:24], rng[15:8] ^ rng[31:24], rng[30:23]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic run_op(input logic [1:0] o, input logic [23:0] b, input int off,
                        input logic [4:0] wc, input bit extra_start);
    int w, n, exp_ffo, exp_bytes, mism, first_one;
    bit exp_n, exp_z, nb;
    logic [31:0] src;
    logic [23:0] exp_a;
    string mtag;
    w = (wc == 0) ? 32 : int'(wc);
    src = next_rng();
    for (int i = 0; i < 64; i++) begin
      logic [31:0] r;
      r = next_rng();
      mem[i] = r[7:0];
      ref_mem[i] = r[7:0];
    end
    // Reference model: walk the field bit by bit from its first bit.
    exp_z = 1'b1; exp_n = 1'b0; first_one = -1;
    for (int i = 0; i < w; i++) begin
      int p;
      logic [23:0] a;
      int bitpos;
      p = off + i;
      a = b + 24'(p >>> 3);
      bitpos = 7 - (p & 7);
      nb = ref_mem[a[5:0]][bitpos];
      if (i == 0) exp_n = nb;
      if (nb) begin
        exp_z = 1'b0;
        if (first_one < 0) first_one = i;
      end
      if (o == 2'b00) ref_mem[a[5:0]][bitpos] = 1'b1;
      else if (o == 2'b01) ref_mem[a[5:0]][bitpos] = src[w-1-i];
    end
    exp_ffo   = off + ((first_one < 0) ? w : first_one);
    exp_bytes = (o[1] == 1'b0 && ((off & 7) + w) > 32) ? 1 : 0;
    exp_a     = b + 24'(off >>> 3);
    word_wr_cnt = 0; byte_wr_cnt = 0; hold_err = 1'b0;
    rd_word_addr = 24'hxxxxxx; rd_byte_addr = 24'hxxxxxx;

    @(negedge clk);
    start = 1'b1; op = o; base_addr = b; bit_off = off; width_code = wc; ins_val = src;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      // R9: this start arrives while busy and must be ignored
      start = 1'b1; op = 2'b00; bit_off = off + 3; width_code = 5'd7; base_addr = b + 24'd5;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R9", "done seen", done, 1);
    chk(flag_n == exp_n && flag_z == exp_z, "R3", "flags n/z", {flag_n, flag_z}, {exp_n, exp_z});
    chk(flag_v == 1'b0 && flag_c == 1'b0, "R3", "flags v/c", {flag_v, flag_c}, 0);
    if (o[1]) chk(ffo_result == 32'(exp_ffo), "R7", "find-first result",
                  ffo_result, 32'(exp_ffo));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done single/busy release", {done, busy}, 0);
    mism = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) mism++;
    mtag = (o == 2'b00) ? "R4" : (o == 2'b01) ? "R5" : "R7";
    if (wc == 0) mtag = {mtag, "/R2"};
    chk(mism == 0, mtag, "memory bytes mismatched", mism, 0);
    chk(word_wr_cnt == (o[1] ? 0 : 1), o[1] ? "R7" : "R4", "word writes",
        word_wr_cnt, o[1] ? 0 : 1);
    chk(byte_wr_cnt == exp_bytes, "R6", "trailing byte writes", byte_wr_cnt, exp_bytes);
    chk(rd_word_addr === exp_a, "R1", "word read address", rd_word_addr, exp_a);
    chk(rd_byte_addr === exp_a + 24'd4, "R1", "byte read address", rd_byte_addr, exp_a + 24'd4);
    chk(!hold_err, "R8", "request held until ack", hold_err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R10", "during reset",
        {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R10", "after reset",
        {busy, done, mem_req}, 0);

    for (int o = 0; o < 3; o++) begin
      for (int wc = 0; wc < 32; wc++) begin
        for (int k = 0; k < 10; k++) begin
          run_op(2'(o), 24'h000020 + 24'(k), -19 + 5 * k, 5'(wc), 1'b0);
        end
      end
    end
    // Boundary: fields ending exactly at bit 32 and one bit past it (R6).
    for (int o = 0; o < 3; o++) begin
      run_op(2'(o), 24'h000010, 8 + 7, 5'd25, 1'b0);
      run_op(2'(o), 24'h000010, 8 + 7, 5'd26, 1'b0);
      run_op(2'(o), 24'h000010, 8 + 1, 5'd0, 1'b0);
    end
    // Address wrap at the top of the 24-bit space and large offsets (R1).
    for (int o = 0; o < 3; o++) begin
      run_op(2'(o), 24'hFFFFFC, -9, 5'd13, 1'b0);
      run_op(2'(o), 24'hFFFFFE, 40, 5'd0, 1'b0);
      run_op(2'(o), 24'h000000, -1000, 5'd17, 1'b0);
      run_op(2'(o), 24'h000100, 1003, 5'd31, 1'b0);
    end
    // Start pulsed while busy (R9).
    for (int o = 0; o < 3; o++) begin
      run_op(2'(o), 24'h000008, 5, 5'd12, 1'b1);
      run_op(2'(o), 24'h000018, -3, 5'd30, 1'b1);
    end
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && mem_req == 1'b0, "R10", "quiet when idle", {busy, mem_req}, 0);
    summary();
    $finish;
  end
endmodule